// File: doc/BRIEF.md
# Programmable-Format Serial Transmitter

This block turns bytes into an asynchronous serial stream on a single output line. A control byte picks the frame shape: how many data bits go out, whether a parity bit follows them and how it is formed, and how long the stop interval lasts. A 16-bit divisor sets the bit rate. Each bit lasts sixteen ticks of a tick that fires once every `divisor` clock cycles. A control bit can also hold the line low to signal a break.

Software programs the block through a narrow write port. Address 3 holds the control byte. Addresses 0 and 1 reach the low and high divisor bytes, but only while the control byte's divisor-access bit is set. Data arrives on a valid/ready byte port backed by a single holding register. The next byte can therefore wait while the current frame is on the line, and frames follow each other with no idle gap.

Top module: `uart_fmt_tx`

## Requirements
- R1: After reset the line is high, the byte port is ready, the divisor is 0 and the control byte is 0. A control byte of 0 sends frames of 5 data bits, no parity and one stop bit.
- R2: Control bits [1:0] pick the data length: 00 = 5, 01 = 6, 10 = 7, 11 = 8 bits. A frame is one low start bit, then the data bits with the least significant bit first. Each bit lasts 16 ticks.
- R3: With control bit 2 clear the stop interval is 16 ticks. With bit 2 set it is 24 ticks for 5-bit data and 32 ticks for 6, 7 or 8-bit data. A waiting byte starts right at the end of the stop interval.
- R4: With control bit 3 clear no parity bit is sent, whatever bits 4 and 5 hold.
- R5: With bit 3 set and bit 5 clear, a parity bit follows the data. Bit 4 = 0 makes the count of ones in data plus parity odd, and bit 4 = 1 makes it even.
- R6: With bits 3 and 5 set, the parity bit is a constant: 1 when bit 4 is 0, and 0 when bit 4 is 1.
- R7: While control bit 6 is set the line is low from the cycle after the write. A frame in progress is dropped and never resumed.
- R8: After control bit 6 clears, the line stays high for at least 16 ticks before any start bit.
- R9: Writes to address 0 or 1 change the divisor low or high byte only while control bit 7 is set. Otherwise they have no effect.
- R10: A divisor of N > 0 gives one tick every N clocks, so a frame of T ticks takes T·N clocks. A divisor of 0 stops all activity on the line.
- R11: The frame format is captured when a start bit begins. Control writes made during a frame affect only later frames.
- R12: `tx_ready` is low while the holding register holds a byte. An offered byte is taken only when `tx_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0/1 divisor bytes, 3 control) |
| wr_data | input | 8 | Register write data |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | `tx_data` is offered |
| tx_ready | output | 1 | Holding register is free |
| tx_line | output | 1 | Serial output, idle high |

## Verification
A table of control and data pairs covers every data length. It sends each stop setting at more than one length and each parity mode on data of even and odd weight. Each frame is sampled bit by bit at mid-bit, which separates wrong bit order, wrong length and wrong parity polarity. The gap between two back-to-back start edges separates the three stop lengths and checks divisor scaling. Directed patterns cover a control write in mid-frame, with data whose upper bits are zero so that a wrongly shortened frame shows up. They also cover a break dropped into a live frame followed by a distinct queued byte, and divisor writes made with and without divisor access.

// File: rtl/uart_fmt_pkg.sv
package uart_fmt_pkg;

   localparam int REG_W = 8;

   typedef struct packed {
      logic       div_access;
      logic       brk;
      logic       par_fixed;
      logic       par_sel;
      logic       par_on;
      logic       stop_long;
      logic [1:0] wlen;
   } line_ctl_t;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_PAR,
      ST_STOP,
      ST_BREAK,
      ST_GUARD
   } tx_state_t;

   function automatic logic par_value(line_ctl_t c, logic [REG_W-1:0] d);
      logic [REG_W-1:0] mask;
      logic             ones_odd;
      mask     = 8'hFF >> (2'd3 - c.wlen);
      ones_odd = ^(d & mask);
      if (c.par_fixed) return ~c.par_sel;
      return c.par_sel ? ones_odd : ~ones_odd;
   endfunction

   function automatic int unsigned stop_ticks(line_ctl_t c, int unsigned os);
      if (!c.stop_long) return os;
      if (c.wlen == 2'b00) return os + os / 2;
      return 2 * os;
   endfunction

endpackage

// File: rtl/uart_fmt_regs.sv
module uart_fmt_regs
   import uart_fmt_pkg::*;
#(
   parameter int ADDR_W      = 2,
   parameter int DIV_W       = 16,
   parameter int ADDR_DIV_LO = 0,
   parameter int ADDR_DIV_HI = 1,
   parameter int ADDR_CTL    = 3,
   parameter logic [DIV_W-1:0] DIV_RESET = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [REG_W-1:0]  wr_data,
   output line_ctl_t         ctl,
   output logic [DIV_W-1:0]  divisor
);

   localparam logic [ADDR_W-1:0] A_LO  = ADDR_W'(ADDR_DIV_LO);
   localparam logic [ADDR_W-1:0] A_HI  = ADDR_W'(ADDR_DIV_HI);
   localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(ADDR_CTL);

   if (DIV_W != 2 * REG_W) begin : g_bad_div
      $error("divisor must span exactly two register bytes");
   end
   if (ADDR_DIV_LO == ADDR_DIV_HI || ADDR_DIV_LO == ADDR_CTL || ADDR_DIV_HI == ADDR_CTL) begin : g_bad_map
      $error("register addresses must be distinct");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl     <= '0;
         divisor <= DIV_RESET;
      end else if (wr_en) begin
         if (wr_addr == A_CTL) begin
            ctl <= line_ctl_t'(wr_data);
         end else if (wr_addr == A_LO && ctl.div_access) begin
            divisor[REG_W-1:0] <= wr_data;
         end else if (wr_addr == A_HI && ctl.div_access) begin
            divisor[DIV_W-1:REG_W] <= wr_data;
         end
      end
   end

   // R9: divisor bytes untouched when divisor access is off
   a_r9_div_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !ctl.div_access && (wr_addr == A_LO || wr_addr == A_HI)) |=> $stable(divisor));

endmodule

// File: rtl/uart_fmt_baud.sv
module uart_fmt_baud #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] divisor,
   output logic             tick
);

   localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

   logic [DIV_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         tick <= 1'b0;
      end else if (divisor == '0) begin
         cnt  <= '0;
         tick <= 1'b0;
      end else if (cnt >= divisor - ONE) begin
         cnt  <= '0;
         tick <= 1'b1;
      end else begin
         cnt  <= cnt + ONE;
         tick <= 1'b0;
      end
   end

   // R10: a zero divisor produces no tick
   a_r10_div_zero_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(divisor) == '0) |-> !tick);

   // R10: with a divisor above one, ticks never land on adjacent cycles
   a_r10_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && divisor > ONE && $stable(divisor)) |=> !tick);

endmodule

// File: rtl/uart_fmt_ser.sv
module uart_fmt_ser
   import uart_fmt_pkg::*;
#(
   parameter int OVERSAMPLE = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  line_ctl_t        ctl,
   input  logic [REG_W-1:0] in_data,
   input  logic             in_valid,
   output logic             in_ready,
   output logic             line_bit
);

   localparam int CNT_W = $clog2(2 * OVERSAMPLE);
   localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(OVERSAMPLE - 1);

   tx_state_t        state;
   logic [CNT_W-1:0] cnt;
   logic [2:0]       bit_idx;
   logic [REG_W-1:0] shreg;
   logic [REG_W-1:0] hold_q;
   logic             hold_full;
   logic [2:0]       nb_m1;
   logic             par_on_q;
   logic             par_bit_q;
   logic [CNT_W-1:0] stop_lim;
   logic             take;
   logic             accept;
   logic             unused_access;

   assign unused_access = ctl.div_access;
   assign in_ready      = !hold_full;
   assign accept        = in_valid && !hold_full;
   assign take = hold_full && tick && !ctl.brk &&
                 (state == ST_IDLE || (state == ST_STOP && cnt == stop_lim));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_full <= 1'b0;
         hold_q    <= '0;
      end else begin
         hold_full <= (hold_full && !take) || accept;
         if (accept) hold_q <= in_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         cnt       <= '0;
         bit_idx   <= '0;
         shreg     <= '0;
         nb_m1     <= 3'd4;
         par_on_q  <= 1'b0;
         par_bit_q <= 1'b0;
         stop_lim  <= BIT_LAST;
      end else if (ctl.brk) begin
         state <= ST_BREAK;
         cnt   <= '0;
      end else begin
         unique case (state)
            ST_BREAK: begin
               state <= ST_GUARD;
               cnt   <= '0;
            end
            ST_GUARD: if (tick) begin
               if (cnt == BIT_LAST) begin
                  state <= ST_IDLE;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_START: if (tick) begin
               if (cnt == BIT_LAST) begin
                  state   <= ST_DATA;
                  cnt     <= '0;
                  bit_idx <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_DATA: if (tick) begin
               if (cnt == BIT_LAST) begin
                  cnt   <= '0;
                  shreg <= shreg >> 1;
                  if (bit_idx == nb_m1) begin
                     state <= par_on_q ? ST_PAR : ST_STOP;
                  end else begin
                     bit_idx <= bit_idx + 1'b1;
                  end
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_PAR: if (tick) begin
               if (cnt == BIT_LAST) begin
                  state <= ST_STOP;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_STOP: if (tick) begin
               if (cnt == stop_lim) begin
                  state <= ST_IDLE;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: ;
         endcase
         if (take) begin
            state     <= ST_START;
            cnt       <= '0;
            shreg     <= hold_q;
            nb_m1     <= 3'd4 + {1'b0, ctl.wlen};
            par_on_q  <= ctl.par_on;
            par_bit_q <= par_value(ctl, hold_q);
            stop_lim  <= CNT_W'(stop_ticks(ctl, OVERSAMPLE) - 1);
         end
      end
   end

   always_comb begin
      unique case (state)
         ST_START, ST_BREAK: line_bit = 1'b0;
         ST_DATA:            line_bit = shreg[0];
         ST_PAR:             line_bit = par_bit_q;
         default:            line_bit = 1'b1;
      endcase
   end

   // R7: a break request moves the sequencer into the break state next cycle
   a_r7_break_enter: assert property (@(posedge clk) disable iff (!rst_n)
      ctl.brk |=> (state == ST_BREAK));

   // R8: a start bit is entered only from idle or from the end of a stop interval
   a_r8_start_origin: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_START && $past(state) != ST_START) |->
         ($past(state) == ST_IDLE || $past(state) == ST_STOP));

   // R12: a held byte stays held until a frame takes it
   a_r12_hold_keep: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_full && !take) |=> hold_full);

   // R11: captured length does not move while data bits are on the line
   a_r11_fmt_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DATA && $past(state) == ST_DATA) |-> $stable(nb_m1));

endmodule

// File: rtl/uart_fmt_tx.sv
module uart_fmt_tx
   import uart_fmt_pkg::*;
#(
   parameter int OVERSAMPLE = 16,
   parameter int ADDR_W     = 2,
   parameter int DIV_W      = 16,
   parameter bit REG_OUT    = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   input  logic [7:0]        tx_data,
   input  logic              tx_valid,
   output logic              tx_ready,
   output logic              tx_line
);

   if (OVERSAMPLE < 4 || (OVERSAMPLE % 2) != 0) begin : g_bad_os
      $error("OVERSAMPLE must be even and at least 4");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("ADDR_W must cover addresses 0 to 3");
   end

   line_ctl_t        ctl;
   logic [DIV_W-1:0] divisor;
   logic             tick;
   logic             line_bit;
   logic             line_raw;

   uart_fmt_regs #(.ADDR_W(ADDR_W), .DIV_W(DIV_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .ctl     (ctl),
      .divisor (divisor)
   );

   uart_fmt_baud #(.DIV_W(DIV_W)) u_baud (
      .clk     (clk),
      .rst_n   (rst_n),
      .divisor (divisor),
      .tick    (tick)
   );

   uart_fmt_ser #(.OVERSAMPLE(OVERSAMPLE)) u_ser (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .ctl      (ctl),
      .in_data  (tx_data),
      .in_valid (tx_valid),
      .in_ready (tx_ready),
      .line_bit (line_bit)
   );

   assign line_raw = ctl.brk ? 1'b0 : line_bit;

   if (REG_OUT) begin : g_out_reg
      logic line_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) line_q <= 1'b1;
         else        line_q <= line_raw;
      end
      assign tx_line = line_q;
   end else begin : g_out_comb
      assign tx_line = line_raw;
   end

   // R10: with the tick stopped the line cannot leave idle on its own
   a_r10_stopped_line: assert property (@(posedge clk) disable iff (!rst_n)
      (divisor == '0 && $past(divisor) == '0 && !ctl.brk && $past(tx_line) && $stable(ctl))
         |-> tx_line);

endmodule

// File: tb/tb_uart_fmt_tx.sv
module tb_uart_fmt_tx;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [7:0] tx_data = '0;
   logic       tx_valid = 1'b0;
   logic       tx_ready;
   logic       tx_line;

   int n_checks = 0;
   int n_fail   = 0;
   int cyc      = 0;
   int t0       = 0;

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   uart_fmt_tx dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_line(tx_line)
   );

   // control[5:0] = {par_fixed, par_sel, par_on, stop_long, wlen[1:0]}, data
   localparam int NV = 14;
   localparam logic [13:0] VEC [NV] = '{
      {6'b000011, 8'hA5}, {6'b000010, 8'h3C}, {6'b000001, 8'h5A}, {6'b000000, 8'h13},
      {6'b000111, 8'h81}, {6'b000100, 8'h0F}, {6'b000101, 8'h2D}, {6'b001011, 8'h07},
      {6'b011011, 8'h07}, {6'b001010, 8'h55}, {6'b101011, 8'h00}, {6'b111011, 8'hFF},
      {6'b110011, 8'h6E}, {6'b011100, 8'h1B}
   };

   task automatic check(input bit ok, input string what, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", what, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic push(input logic [7:0] d);
      @(negedge clk);
      tx_data = d; tx_valid = 1'b1;
      while (!tx_ready) @(negedge clk);
      @(negedge clk);
      tx_valid = 1'b0;
   endtask

   function automatic int nbits(input logic [5:0] c);
      return 5 + int'(c[1:0]);
   endfunction

   function automatic logic exp_par(input logic [5:0] c, input logic [7:0] d);
      int ones = 0;
      for (int i = 0; i < nbits(c); i++) ones += int'(d[i]);
      if (c[5]) return !c[4];
      if (c[4]) return logic'(ones % 2);
      return logic'((ones + 1) % 2);
   endfunction

   function automatic int exp_ticks(input logic [5:0] c);
      int st;
      st = !c[2] ? 16 : (c[1:0] == 2'b00 ? 24 : 32);
      return 16 * (1 + nbits(c) + int'(c[3])) + st;
   endfunction

   task automatic mon(input logic [5:0] c, input logic [7:0] d, input int dv);
      string ptag;
      ptag = c[5] ? "R6 forced parity" : "R5 parity";
      @(negedge clk);
      while (tx_line) @(negedge clk);
      t0 = cyc;
      repeat (8 * dv) @(negedge clk);
      check(tx_line == 1'b0, "R2 start bit", int'(tx_line), 0);
      for (int i = 0; i < nbits(c); i++) begin
         repeat (16 * dv) @(negedge clk);
         check(tx_line == d[i], "R2 data bit", int'(tx_line), int'(d[i]));
      end
      if (c[3]) begin
         repeat (16 * dv) @(negedge clk);
         check(tx_line == exp_par(c, d), ptag, int'(tx_line), int'(exp_par(c, d)));
      end
      repeat (16 * dv) @(negedge clk);
      check(tx_line == 1'b1, c[3] ? "R3 stop bit" : "R4 no parity, stop in place",
            int'(tx_line), 1);
   endtask

   task automatic run_frame(input logic [5:0] c, input logic [7:0] d, input int dv);
      int t1;
      wr(2'd3, {2'b00, c});
      fork
         begin push(d); push(~d); end
      join_none
      mon(c, d, dv);
      while (!tx_line) @(negedge clk);
      while (tx_line) @(negedge clk);
      t1 = cyc;
      check((t1 - t0) == dv * exp_ticks(c), dv > 1 ? "R10 frame period" : "R3 frame period",
            t1 - t0, dv * exp_ticks(c));
      repeat (dv * exp_ticks(c) + 8 * dv) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      int lows;
      repeat (5) @(negedge clk);
      check(tx_line == 1'b1, "R1 reset line", int'(tx_line), 1);
      check(tx_ready == 1'b1, "R1 reset ready", int'(tx_ready), 1);
      rst_n = 1'b1;

      // divisor is 0 after reset: nothing moves
      push(8'h96);
      lows = 0;
      repeat (300) begin @(negedge clk); if (!tx_line) lows++; end
      check(lows == 0, "R10 zero divisor stops line", lows, 0);
      check(tx_ready == 1'b0, "R12 ready low while held", int'(tx_ready), 0);

      // divisor byte write without divisor access is ignored
      wr(2'd0, 8'h01);
      lows = 0;
      repeat (300) begin @(negedge clk); if (!tx_line) lows++; end
      check(lows == 0, "R9 gated divisor write", lows, 0);

      wr(2'd3, 8'h80);
      wr(2'd0, 8'h01);
      wr(2'd1, 8'h00);
      wr(2'd3, 8'h00);
      mon(6'b000000, 8'h96, 1);   // R1 default format: 5 bits, no parity, 1 stop
      repeat (40) @(negedge clk);
      check(tx_ready == 1'b1, "R12 ready after take", int'(tx_ready), 1);

      for (int v = 0; v < NV; v++) run_frame(VEC[v][13:8], VEC[v][7:0], 1);

      // divisor 2
      wr(2'd3, 8'h80);
      wr(2'd0, 8'h02);
      wr(2'd3, 8'h00);
      run_frame(6'b000011, 8'hC3, 2);
      wr(2'd3, 8'h80);
      wr(2'd0, 8'h01);
      wr(2'd3, 8'h00);

      // R11: switch to 5-bit format while an 8-bit frame runs
      wr(2'd3, 8'h03);
      fork
         push(8'h1F);
         begin
            @(negedge clk);
            while (tx_line) @(negedge clk);
            repeat (40) @(negedge clk);
            wr(2'd3, 8'h00);
         end
      join_none
      mon(6'b000011, 8'h1F, 1);
      repeat (40) @(negedge clk);
      fork push(8'h0A); join_none
      mon(6'b000000, 8'h0A, 1);   // R11 next frame uses the new 5-bit format
      repeat (60) @(negedge clk);

      // R7 / R8: break during a live frame, queued byte follows after guard
      wr(2'd3, 8'h03);
      fork
         begin push(8'h00); push(8'h6B); end
      join_none
      @(negedge clk);
      while (tx_line) @(negedge clk);
      repeat (50) @(negedge clk);
      wr(2'd3, 8'h43);
      lows = 0;
      repeat (100) begin if (!tx_line) lows++; @(negedge clk); end
      check(lows == 100, "R7 break holds line low", lows, 100);
      wr(2'd3, 8'h03);
      @(negedge clk);
      lows = 0;
      repeat (16) begin if (!tx_line) lows++; @(negedge clk); end
      check(lows == 0, "R8 idle guard after break", lows, 0);
      mon(6'b000011, 8'h6B, 1);   // R7 dropped frame not resumed
      repeat (60) @(negedge clk);
      check(tx_line == 1'b1, "R2 idle high", int'(tx_line), 1);

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule